// File: doc/BRIEF.md
# Three-Dimensional Strided DMA Address Generator

This block turns one DMA channel's parameter set into a stream of burst descriptors. A transfer is a block of frames. Each frame holds a number of arrays, and each array is a run of contiguous bytes. Every descriptor carries a source byte address, a destination byte address and a byte length. Source and destination each have their own signed step between arrays and their own signed step between frames. Bus mastering and data movement are left to whatever consumes the descriptors.

A sync event starts one unit of work. In single-array mode a unit is one array. In whole-frame mode a unit is every array of the current frame, issued on back-to-back cycles. Two pulses report progress: a unit pulse at the end of each unit, and a final pulse when the last frame finishes. At that point the active set is either disarmed or replaced by a stored set named in its link field. A replaced set waits for its own events before it starts.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset no descriptor is valid, both completion pulses are low and `armed` is low (a frame count of zero means unarmed).
- R2: In single-array mode (`cfg_ab`=0), each accepted event produces exactly one descriptor. It is valid in the cycle after the clock edge that samples the event, its length equals the byte count, and `unit_done` is high in that same cycle.
- R3: Arrays of one frame follow each other at the sign-extended 16-bit array stride, applied separately to source and destination, in both modes. Address sums wrap modulo 2^32.
- R4: In single-array mode, the first array of a new frame starts at the start of the previous frame's last array plus the sign-extended frame stride. That new frame then holds the reload count of arrays. The first frame holds the initial array count.
- R5: In whole-frame mode (`cfg_ab`=1), each accepted event produces all arrays of one frame as descriptors on consecutive cycles, starting the cycle after the event. `unit_done` is high only on the last of them.
- R6: In whole-frame mode, each frame starts at the previous frame's first array address plus the sign-extended frame stride. The reload count has no effect.
- R7: `final_done` is high together with `unit_done` on the last descriptor of the last frame and at no other time. With a link value of 0xFFFF, `armed` is low from the next cycle.
- R8: When the last frame ends and the link value is not 0xFFFF, the active set is replaced in the next cycle by stored slot `link[SW-1:0]`. No descriptor is issued until a new event arrives.
- R9: An event is ignored while a descriptor run is in progress or while the channel is unarmed. Array counts and frame counts are assumed nonzero.
- R10: A write to the active set (`cfg_wr` with `cfg_active`=1) is ignored while a descriptor run is in progress or in the cycle an event is accepted. Writes with `cfg_active`=0 store into slot `cfg_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Parameter write strobe |
| cfg_active | input | 1 | 1: write active set, 0: write stored slot |
| cfg_slot | input | SW | Stored slot index |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_acnt | input | CW | Bytes per array |
| cfg_bcnt | input | CW | Arrays in the first frame |
| cfg_ccnt | input | CW | Frames per block |
| cfg_sstep_a | input | 16 | Signed source array stride |
| cfg_dstep_a | input | 16 | Signed destination array stride |
| cfg_sstep_f | input | 16 | Signed source frame stride |
| cfg_dstep_f | input | 16 | Signed destination frame stride |
| cfg_brld | input | CW | Array count reload for later frames (single-array mode) |
| cfg_link | input | 16 | Linked slot, 0xFFFF for none |
| cfg_ab | input | 1 | 0: single-array mode, 1: whole-frame mode |
| sync_evt | input | 1 | Sync event |
| armed | output | 1 | Active set has frames left |
| desc_valid | output | 1 | Descriptor valid |
| desc_src | output | AW | Descriptor source address |
| desc_dst | output | AW | Descriptor destination address |
| desc_len | output | CW | Descriptor byte length |
| unit_done | output | 1 | Unit finished (intermediate completion) |
| final_done | output | 1 | Block finished |

## Verification
Both modes are swept across array counts and frame counts of one to three and three stride sets. One stride set is positive and small. One mixes negative strides, the extreme stride values and a start address near the top of the address space, so wrapping shows up. One uses large mixed-sign strides. The reload count always differs from the initial array count, so single-array runs separate the initial count from the reload count. They also separate a frame step taken from the last array from one taken from the frame start, which is the rule whole-frame runs follow. Directed cases cover link reload without an automatic start, an event and an active-set write injected mid-run, and events sent to a disarmed channel.

// File: rtl/strided_addr_gen.sv
module strided_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int NSETS = 4,
  localparam int SW = $clog2(NSETS),
  localparam int PW = 2*AW + 4*CW + 4*16 + 16 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_active,
  input  logic [SW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_acnt,
  input  logic [CW-1:0] cfg_bcnt,
  input  logic [CW-1:0] cfg_ccnt,
  input  logic [15:0]   cfg_sstep_a,
  input  logic [15:0]   cfg_dstep_a,
  input  logic [15:0]   cfg_sstep_f,
  input  logic [15:0]   cfg_dstep_f,
  input  logic [CW-1:0] cfg_brld,
  input  logic [15:0]   cfg_link,
  input  logic          cfg_ab,
  input  logic          sync_evt,
  output logic          armed,
  output logic          desc_valid,
  output logic [AW-1:0] desc_src,
  output logic [AW-1:0] desc_dst,
  output logic [CW-1:0] desc_len,
  output logic          unit_done,
  output logic          final_done
);

  localparam logic [15:0] NO_LINK = 16'hFFFF;

  function automatic logic [AW-1:0] sx(input logic [15:0] v);
    return {{(AW-16){v[15]}}, v};
  endfunction

  logic [PW-1:0] tbl [NSETS];
  logic [PW-1:0] cfg_pack;

  logic [AW-1:0] a_src, a_dst;
  logic [CW-1:0] a_acnt, a_bcnt, a_ccnt, a_rld;
  logic [15:0]   a_sb, a_db, a_sc, a_dc, a_link;
  logic          a_ab;

  logic [AW-1:0] w_src, w_dst;
  logic [CW-1:0] w_k;
  logic          run;

  logic start, last_arr, frame_end, reload;

  assign cfg_pack = {cfg_ab, cfg_link, cfg_dstep_f, cfg_sstep_f, cfg_dstep_a, cfg_sstep_a,
                     cfg_brld, cfg_ccnt, cfg_bcnt, cfg_acnt, cfg_dst, cfg_src};

  assign armed      = a_ccnt != '0;
  assign start      = sync_evt && !run && armed;
  assign last_arr   = w_k == CW'(1);
  assign frame_end  = a_ab || (a_bcnt == CW'(1));
  assign desc_valid = run;
  assign desc_src   = w_src;
  assign desc_dst   = w_dst;
  assign desc_len   = a_acnt;
  assign unit_done  = run && last_arr;
  assign final_done = unit_done && frame_end && (a_ccnt == CW'(1));
  assign reload     = final_done && (a_link != NO_LINK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) tbl[i] <= '0;
    end else if (cfg_wr && !cfg_active) begin
      tbl[cfg_slot] <= cfg_pack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {a_ab, a_link, a_dc, a_sc, a_db, a_sb, a_rld, a_ccnt, a_bcnt, a_acnt, a_dst, a_src} <= '0;
      w_src <= '0;
      w_dst <= '0;
      w_k   <= '0;
      run   <= 1'b0;
    end else if (start) begin
      run   <= 1'b1;
      w_src <= a_src;
      w_dst <= a_dst;
      w_k   <= a_ab ? a_bcnt : CW'(1);
    end else if (run) begin
      if (!last_arr) begin
        w_src <= w_src + sx(a_sb);
        w_dst <= w_dst + sx(a_db);
        w_k   <= w_k - CW'(1);
      end else begin
        run <= 1'b0;
        if (reload) begin
          {a_ab, a_link, a_dc, a_sc, a_db, a_sb, a_rld, a_ccnt, a_bcnt, a_acnt, a_dst, a_src}
            <= tbl[a_link[SW-1:0]];
        end else if (a_ab) begin
          a_src  <= a_src + sx(a_sc);
          a_dst  <= a_dst + sx(a_dc);
          a_ccnt <= a_ccnt - CW'(1);
        end else if (a_bcnt == CW'(1)) begin
          a_src  <= w_src + sx(a_sc);
          a_dst  <= w_dst + sx(a_dc);
          a_bcnt <= a_rld;
          a_ccnt <= a_ccnt - CW'(1);
        end else begin
          a_src  <= w_src + sx(a_sb);
          a_dst  <= w_dst + sx(a_db);
          a_bcnt <= a_bcnt - CW'(1);
        end
      end
    end else if (cfg_wr && cfg_active) begin
      {a_ab, a_link, a_dc, a_sc, a_db, a_sb, a_rld, a_ccnt, a_bcnt, a_acnt, a_dst, a_src} <= cfg_pack;
    end
  end

  // R3
  step_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !unit_done |=> desc_valid && desc_src == $past(desc_src) + sx($past(a_sb)));

  // R2
  single_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !a_ab |=> !desc_valid);

  // R5
  unit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> !desc_valid);

  // R7
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_done && a_link == NO_LINK |=> !armed);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !unit_done |=> $stable(a_ccnt) && $stable(a_src) && $stable(desc_len));

endmodule

// File: tb/strided_addr_gen_test.sv
module strided_addr_gen_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        cfg_wr = 0, cfg_active = 0, cfg_ab = 0, sync_evt = 0;
  logic [1:0]  cfg_slot = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0;
  logic [15:0] cfg_acnt = 0, cfg_bcnt = 0, cfg_ccnt = 0, cfg_brld = 0;
  logic [15:0] cfg_sstep_a = 0, cfg_dstep_a = 0, cfg_sstep_f = 0, cfg_dstep_f = 0;
  logic [15:0] cfg_link = 16'hFFFF;
  logic        armed, desc_valid, unit_done, final_done;
  logic [31:0] desc_src, desc_dst;
  logic [15:0] desc_len;

  int checks = 0, errors = 0;

  strided_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_active(cfg_active), .cfg_slot(cfg_slot),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_acnt(cfg_acnt), .cfg_bcnt(cfg_bcnt),
    .cfg_ccnt(cfg_ccnt), .cfg_sstep_a(cfg_sstep_a), .cfg_dstep_a(cfg_dstep_a),
    .cfg_sstep_f(cfg_sstep_f), .cfg_dstep_f(cfg_dstep_f), .cfg_brld(cfg_brld),
    .cfg_link(cfg_link), .cfg_ab(cfg_ab), .sync_evt(sync_evt), .armed(armed),
    .desc_valid(desc_valid), .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
    .unit_done(unit_done), .final_done(final_done));

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit ab, input logic [31:0] s, d, input int a, b, rld, c,
                         input logic [15:0] sb, db, sc, dc, lk);
    cfg_ab = ab; cfg_src = s; cfg_dst = d; cfg_acnt = 16'(a); cfg_bcnt = 16'(b);
    cfg_brld = 16'(rld); cfg_ccnt = 16'(c); cfg_sstep_a = sb; cfg_dstep_a = db;
    cfg_sstep_f = sc; cfg_dstep_f = dc; cfg_link = lk;
  endtask

  task automatic push(input bit act, input logic [1:0] slot);
    @(negedge clk);
    cfg_wr = 1; cfg_active = act; cfg_slot = slot;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse();
    @(negedge clk);
    sync_evt = 1;
    @(negedge clk);
    sync_evt = 0;
  endtask

  task automatic desc_ck(input string req, input logic [31:0] s, d, input int a,
                         input bit u, input bit f);
    ck({req, " valid"}, 32'(desc_valid), 1);
    ck({req, " src"}, desc_src, s);
    ck({req, " dst"}, desc_dst, d);
    ck({req, " len"}, 32'(desc_len), 32'(a));
    ck({req, " unit"}, 32'(unit_done), 32'(u));
    ck({req, " final R7"}, 32'(final_done), 32'(f));
  endtask

  task automatic run_block(input bit ab, input logic [31:0] s, d, input int a, b, rld, c,
                           input logic [15:0] sb, db, sc, dc);
    logic [31:0] es, ed, fs, fd;
    int bc;
    set_cfg(ab, s, d, a, b, rld, c, sb, db, sc, dc, 16'hFFFF);
    push(1, 0);
    es = s; ed = d; fs = s; fd = d; bc = b;
    for (int f = 0; f < c; f++) begin
      if (!ab) begin
        for (int k = 0; k < bc; k++) begin
          pulse();
          desc_ck("R2 R3 R4", es, ed, a, 1, (f == c-1) && (k == bc-1));
          @(negedge clk);
          ck("R2 single", 32'(desc_valid), 0);
          if (k < bc-1) begin es = es + sx(sb); ed = ed + sx(db); end
          else begin es = es + sx(sc); ed = ed + sx(dc); end
        end
        bc = rld;
      end else begin
        pulse();
        es = fs; ed = fd;
        for (int k = 0; k < b; k++) begin
          desc_ck("R5 R3 R6", es, ed, a, k == b-1, (f == c-1) && (k == b-1));
          @(negedge clk);
          es = es + sx(sb); ed = ed + sx(db);
        end
        ck("R5 end", 32'(desc_valid), 0);
        fs = fs + sx(sc); fd = fd + sx(dc);
      end
    end
    ck("R7 disarmed", 32'(armed), 0);
    pulse();
    ck("R9 unarmed event", 32'(desc_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ss [3];
    logic [31:0] dd [3];
    logic [15:0] p [3][4];
    ss[0] = 32'h0000_1000; dd[0] = 32'h0000_2000;
    ss[1] = 32'hFFFF_FFF0; dd[1] = 32'h0000_0010;
    ss[2] = 32'h8000_0000; dd[2] = 32'h0000_0100;
    p[0][0] = 16'd1;    p[0][1] = 16'd3;    p[0][2] = 16'd2;    p[0][3] = 16'd5;
    p[1][0] = 16'hFFFC; p[1][1] = 16'h7FFF; p[1][2] = 16'h8000; p[1][3] = 16'd0;
    p[2][0] = 16'd100;  p[2][1] = 16'hFFFF; p[2][2] = 16'hFED4; p[2][3] = 16'd7;

    repeat (3) @(negedge clk);
    // R1 reset state
    ck("R1 valid", 32'(desc_valid), 0);
    ck("R1 unit", 32'(unit_done), 0);
    ck("R1 final", 32'(final_done), 0);
    ck("R1 armed", 32'(armed), 0);
    rst_n = 1;
    pulse();
    ck("R9 event before config", 32'(desc_valid), 0);

    for (int ab = 0; ab < 2; ab++)
      for (int b = 1; b <= 3; b++)
        for (int c = 1; c <= 3; c++)
          for (int st = 0; st < 3; st++)
            run_block(ab[0], ss[st], dd[st], b + st + 1, b, (b % 3) + 1, c,
                      p[st][0], p[st][1], p[st][2], p[st][3]);

    // R8 link reload: slot 2 holds a whole-frame set, active is single-array linking to it
    set_cfg(1, 32'h5000, 32'h6000, 8, 2, 1, 1, 16'd16, 16'hFFF0, 16'd0, 16'd0, 16'hFFFF);
    push(0, 2);
    set_cfg(0, 32'h0100, 32'h0200, 4, 1, 1, 1, 16'd1, 16'd1, 16'd1, 16'd1, 16'h0002);
    push(1, 0);
    pulse();
    desc_ck("R8 first set", 32'h0100, 32'h0200, 4, 1, 1);
    repeat (3) begin
      @(negedge clk);
      ck("R8 no auto start", 32'(desc_valid), 0);
    end
    ck("R8 armed after reload", 32'(armed), 1);
    pulse();
    desc_ck("R8 linked set", 32'h5000, 32'h6000, 8, 0, 0);
    @(negedge clk);
    desc_ck("R8 linked set", 32'h5010, 32'h5FF0, 8, 1, 1);
    @(negedge clk);
    ck("R8 linked set done", 32'(armed), 0);

    // R9 R10 event and active write during a run
    set_cfg(1, 32'h0040, 32'h0080, 2, 3, 1, 2, 16'd4, 16'd8, 16'h0100, 16'h0200, 16'hFFFF);
    push(1, 0);
    pulse();
    desc_ck("R9 run", 32'h0040, 32'h0080, 2, 0, 0);
    sync_evt = 1;
    set_cfg(0, 32'h9999, 32'h9999, 9, 1, 1, 1, 16'd0, 16'd0, 16'd0, 16'd0, 16'hFFFF);
    cfg_wr = 1; cfg_active = 1;
    @(negedge clk);
    sync_evt = 0; cfg_wr = 0;
    desc_ck("R9 R10 run", 32'h0044, 32'h0088, 2, 0, 0);
    @(negedge clk);
    desc_ck("R9 R10 run", 32'h0048, 32'h0090, 2, 1, 0);
    @(negedge clk);
    ck("R9 no retrigger", 32'(desc_valid), 0);
    pulse();
    desc_ck("R10 frame two", 32'h0140, 32'h0280, 2, 0, 0);
    @(negedge clk);
    @(negedge clk);
    desc_ck("R10 frame two", 32'h0148, 32'h0290, 2, 1, 1);
    @(negedge clk);
    ck("R7 R10 disarmed", 32'(armed), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule